// File: doc/BRIEF.md
# Multi-Ring Scratch Queue Manager

This block keeps up to sixteen circular queues of 32-bit words inside one shared on-chip scratch memory. Each queue (ring) has its own base, size code, head offset, tail offset and word count. These are loaded through a small configuration write port before the rings are used. A requester then issues GET commands, which pop words from the head, and PUT commands, which push words at the tail. Each command moves one to sixteen words. The block drives a single-port synchronous memory, returns read words to the requester and signals completion on the final data phase.

Every command owns the memory from its first data phase to its last, so no other access can slip in between. A GET that asks for more words than the ring holds does not wait and does not touch memory. Instead it returns one nil phase. A PUT is never refused, because the requester is responsible for free space. Each ring also has a fill flag that rises once the ring holds at least a quarter of its capacity.

Top module: `scr_ring_mgr`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `mem_en`, `rsp_valid`, `done` and all `ring_full` bits are 0.
- R2: The memory byte address has bits 1:0 at 00. Size codes 0/1/2/3 give rings of 128/256/512/1024 words. For these codes, address bits 13:9 / 13:10 / 13:11 / 13:12 come from the matching upper bits of the 5-bit base field, and address bits 8:2 / 9:2 / 10:2 / 11:2 come from the ring offset.
- R3: A GET of length L on a ring holding at least L words accesses offsets head, head+1, … modulo the ring size on L back-to-back cycles. Each word appears on `rsp_data` with `rsp_valid` one cycle after its access. Head then advances by L modulo the size, and the count drops by L.
- R4: A GET of length L on a ring holding fewer than L words makes no memory access. It gives exactly one phase with `rsp_valid`=1, `rsp_nil`=1 and `rsp_data`=0 in the cycle after acceptance, and it leaves head and count unchanged.
- R5: `done` is high only with the last data word of a GET or with the single nil phase of a refused GET. It is 0 on the earlier words.
- R6: A PUT of length L always proceeds, whatever the count. On each of its L cycles `mem_en`, `mem_we` and `put_pull` are high and `put_data` is written at offsets tail, tail+1, … modulo the size. Tail then advances by L and the count rises by L. No `rsp_valid` is produced.
- R7: `busy` is high during every data phase of a command. A `cmd_valid` seen while `busy` is high is ignored.
- R8: `ring_full[r]` is 1 exactly when ring r's count is at least 32, 64, 128 or 256 for size codes 0 to 3.
- R9: `cfg_sel`=0 loads the base from `cfg_wdata[4:0]` and the size code from `cfg_wdata[9:8]`, and clears head, tail and count.
- R10: `cfg_sel`=1 (head) or 2 (tail) loads that offset from `cfg_wdata[9:0]`, reduced modulo the ring size, and sets the count to (tail − head) modulo the size. `cfg_sel`=3 changes nothing.
- R11: A configuration write is dropped when `busy` or `cmd_valid` is high in the same cycle.
- R12: For a PUT, `done` is high in the cycle after the last write. Commands take the length as `cmd_len_m1`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ring | input | 4 | Ring addressed by the configuration write |
| cfg_sel | input | 2 | 0 layout, 1 head, 2 tail, 3 none |
| cfg_wdata | input | 10 | Configuration value |
| cmd_valid | input | 1 | Command request, taken when `busy` is low |
| cmd_put | input | 1 | 1 for PUT, 0 for GET |
| cmd_ring | input | 4 | Ring addressed by the command |
| cmd_len_m1 | input | 4 | Command length minus one |
| busy | output | 1 | Command data phases in progress |
| put_pull | output | 1 | `put_data` is consumed this cycle |
| put_data | input | 32 | Word supplied for a PUT |
| rsp_valid | output | 1 | GET response phase |
| rsp_nil | output | 1 | Response is the nil phase of a refused GET |
| rsp_data | output | 32 | GET read word, 0 for nil |
| done | output | 1 | Command completion |
| ring_full | output | 16 | Per-ring fill flag |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 14 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, one cycle after the access |

## Verification
The bench uses the default parameters: sixteen rings, commands of up to sixteen words, four size codes starting at 128 words, and a 14-bit byte address backed by a 4096-word memory model. With the 128-word ring, the fill flag's 32-word threshold is reached in two or three PUTs, and a sixteen-word command can straddle the end of the ring. PUTs can also be stacked past the full capacity to show that none is refused. With sixteen rings on random layouts, all four address compositions are exercised, along with rings that overlap in the shared memory.

// File: rtl/scr_ring_pkg.sv
// Shared encodings for the scratch ring manager.
// Assumes: nothing beyond IEEE 1800-2017.
package scr_ring_pkg;

    // Configuration field selector carried on cfg_sel.
    typedef enum logic [1:0] {
        CFG_LAYOUT = 2'd0,
        CFG_HEAD   = 2'd1,
        CFG_TAIL   = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_sel_e;

    // Command sequencer state.
    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_XFER = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/ring_addr_gen.sv
// Builds the memory byte address of a ring word.
// What: the upper address bits come from the base field and the lower word
// bits come from the ring offset; the split point moves with the size code.
// Assumes: ADDR_W-2 == BASE_W + MIN_SIZE_LOG2; offset already reduced modulo size.
module ring_addr_gen #(
    parameter int ADDR_W        = 14,
    parameter int MIN_SIZE_LOG2 = 7,
    parameter int NUM_CODES     = 4,
    localparam int WADDR_W = ADDR_W - 2,
    localparam int BASE_W  = WADDR_W - MIN_SIZE_LOG2,
    localparam int CODE_W  = $clog2(NUM_CODES),
    localparam int OFF_W   = MIN_SIZE_LOG2 + NUM_CODES - 1
) (
    input  logic [BASE_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);

    logic [WADDR_W-1:0] keep_low;
    logic [WADDR_W-1:0] base_word;
    logic [WADDR_W-1:0] word_addr;

    // Mask of the word-address bits that belong to the offset.
    always_comb keep_low = ~({WADDR_W{1'b1}} << (MIN_SIZE_LOG2 + int'(code)));

    // Merge base and offset at the split point, append the byte lane bits.
    always_comb begin
        base_word = {base, {MIN_SIZE_LOG2{1'b0}}};
        word_addr = (base_word & ~keep_low) | (WADDR_W'(offset) & keep_low);
        addr      = {word_addr, 2'b00};
    end

endmodule

// File: rtl/ring_ctx_file.sv
// Per-ring context storage: base, size code, head, tail, count and fill flag.
// What: applies configuration writes and command commits, and reads out one
// ring's context for the command sequencer.
// Assumes: cfg_we is already gated against commands; a commit and a
// configuration write never target the same cycle.
module ring_ctx_file
    import scr_ring_pkg::*;
#(
    parameter int NUM_RINGS     = 16,
    parameter int MAX_LEN       = 16,
    parameter int ADDR_W        = 14,
    parameter int MIN_SIZE_LOG2 = 7,
    parameter int NUM_CODES     = 4,
    localparam int RING_W  = $clog2(NUM_RINGS),
    localparam int LEN_W   = $clog2(MAX_LEN),
    localparam int WADDR_W = ADDR_W - 2,
    localparam int BASE_W  = WADDR_W - MIN_SIZE_LOG2,
    localparam int CODE_W  = $clog2(NUM_CODES),
    localparam int OFF_W   = MIN_SIZE_LOG2 + NUM_CODES - 1,
    localparam int CNT_W   = OFF_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [RING_W-1:0]    cfg_ring,
    input  logic [1:0]           cfg_sel,
    input  logic [OFF_W-1:0]     cfg_wdata,
    input  logic                 cmt_en,
    input  logic                 cmt_put,
    input  logic [RING_W-1:0]    cmt_ring,
    input  logic [LEN_W:0]       cmt_len,
    input  logic [RING_W-1:0]    rd_ring,
    output logic [BASE_W-1:0]    rd_base,
    output logic [CODE_W-1:0]    rd_code,
    output logic [OFF_W-1:0]     rd_head,
    output logic [OFF_W-1:0]     rd_tail,
    output logic [CNT_W-1:0]     rd_count,
    output logic [OFF_W-1:0]     rd_mask,
    output logic [NUM_RINGS-1:0] ring_full
);

    logic [BASE_W-1:0] base_a [NUM_RINGS];
    logic [CODE_W-1:0] code_a [NUM_RINGS];
    logic [OFF_W-1:0]  head_a [NUM_RINGS];
    logic [OFF_W-1:0]  tail_a [NUM_RINGS];
    logic [CNT_W-1:0]  cnt_a  [NUM_RINGS];
    logic [OFF_W-1:0]  mask_a [NUM_RINGS];

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        logic [BASE_W-1:0] base_q;
        logic [CODE_W-1:0] code_q;
        logic [OFF_W-1:0]  head_q;
        logic [OFF_W-1:0]  tail_q;
        logic [CNT_W-1:0]  cnt_q;
        logic [OFF_W-1:0]  mask_w;
        logic [CNT_W-1:0]  thr_w;
        logic [OFF_W-1:0]  new_off;
        logic              hit_cfg;
        logic              hit_cmt;

        // Offset mask and fill threshold (a quarter of the ring) for this ring.
        always_comb begin
            mask_w  = ~({OFF_W{1'b1}} << (MIN_SIZE_LOG2 + int'(code_q)));
            thr_w   = (CNT_W'(mask_w) + CNT_W'(1)) >> 2;
            new_off = cfg_wdata & mask_w;
            hit_cfg = cfg_we && (cfg_ring == RING_W'(g));
            hit_cmt = cmt_en && (cmt_ring == RING_W'(g));
        end

        // Context update from command commits and configuration writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                code_q <= '0;
                head_q <= '0;
                tail_q <= '0;
                cnt_q  <= '0;
            end else if (hit_cmt) begin
                if (cmt_put) begin
                    tail_q <= (tail_q + OFF_W'(cmt_len)) & mask_w;
                    cnt_q  <= cnt_q + CNT_W'(cmt_len);
                end else begin
                    head_q <= (head_q + OFF_W'(cmt_len)) & mask_w;
                    cnt_q  <= cnt_q - CNT_W'(cmt_len);
                end
            end else if (hit_cfg) begin
                case (cfg_sel_e'(cfg_sel))
                    CFG_LAYOUT: begin
                        base_q <= cfg_wdata[BASE_W-1:0];
                        code_q <= cfg_wdata[OFF_W-1 -: CODE_W];
                        head_q <= '0;
                        tail_q <= '0;
                        cnt_q  <= '0;
                    end
                    CFG_HEAD: begin
                        head_q <= new_off;
                        cnt_q  <= CNT_W'((tail_q - new_off) & mask_w);
                    end
                    CFG_TAIL: begin
                        tail_q <= new_off;
                        cnt_q  <= CNT_W'((new_off - head_q) & mask_w);
                    end
                    default: ;
                endcase
            end
        end

        assign base_a[g]    = base_q;
        assign code_a[g]    = code_q;
        assign head_a[g]    = head_q;
        assign tail_a[g]    = tail_q;
        assign cnt_a[g]     = cnt_q;
        assign mask_a[g]    = mask_w;
        assign ring_full[g] = (cnt_q >= thr_w);

        AST_GET_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_cmt && !cmt_put) |-> (cnt_q >= CNT_W'(cmt_len))); // R3
    end

    // Read port toward the sequencer.
    always_comb begin
        rd_base  = base_a[rd_ring];
        rd_code  = code_a[rd_ring];
        rd_head  = head_a[rd_ring];
        rd_tail  = tail_a[rd_ring];
        rd_count = cnt_a[rd_ring];
        rd_mask  = mask_a[rd_ring];
    end

endmodule

// File: rtl/ring_xfer_ctrl.sv
// Command sequencer: accepts one command, decides underflow, commits the
// pointer update at acceptance and then runs the data phases back to back.
// Assumes: the memory returns read data one cycle after the access; the
// requester keeps PUTs within free space.
module ring_xfer_ctrl
    import scr_ring_pkg::*;
#(
    parameter int MAX_LEN       = 16,
    parameter int ADDR_W        = 14,
    parameter int MIN_SIZE_LOG2 = 7,
    parameter int NUM_CODES     = 4,
    localparam int LEN_W   = $clog2(MAX_LEN),
    localparam int WADDR_W = ADDR_W - 2,
    localparam int BASE_W  = WADDR_W - MIN_SIZE_LOG2,
    localparam int CODE_W  = $clog2(NUM_CODES),
    localparam int OFF_W   = MIN_SIZE_LOG2 + NUM_CODES - 1,
    localparam int CNT_W   = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_put,
    input  logic [LEN_W-1:0]  cmd_len_m1,
    input  logic [BASE_W-1:0] sel_base,
    input  logic [CODE_W-1:0] sel_code,
    input  logic [OFF_W-1:0]  sel_head,
    input  logic [OFF_W-1:0]  sel_tail,
    input  logic [CNT_W-1:0]  sel_count,
    input  logic [OFF_W-1:0]  sel_mask,
    output logic              busy,
    output logic              cmt_en,
    output logic [LEN_W:0]    cmt_len,
    output logic              mem_en,
    output logic              mem_we,
    output logic              put_pull,
    output logic [BASE_W-1:0] cur_base,
    output logic [CODE_W-1:0] cur_code,
    output logic [OFF_W-1:0]  cur_off,
    output logic              rsp_valid,
    output logic              rsp_nil,
    output logic              done
);

    xfer_state_e       state_q;
    logic              put_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  last_idx_q;
    logic [OFF_W-1:0]  start_q;
    logic [OFF_W-1:0]  mask_q;
    logic [BASE_W-1:0] base_q;
    logic [CODE_W-1:0] code_q;
    logic              rdv_q;
    logic              nil_q;
    logic              done_q;

    logic accept;
    logic room_ok;
    logic nil_start;
    logic in_xfer;
    logic is_last;

    // Acceptance and underflow decision on the addressed ring.
    always_comb begin
        cmt_len   = {1'b0, cmd_len_m1} + 1'b1;
        accept    = cmd_valid && (state_q == XS_IDLE);
        room_ok   = cmd_put || (sel_count >= CNT_W'(cmt_len));
        cmt_en    = accept && room_ok;
        nil_start = accept && !room_ok;
        in_xfer   = (state_q == XS_XFER);
        is_last   = (idx_q == last_idx_q);
    end

    // Data-phase outputs toward memory and requester.
    always_comb begin
        busy     = in_xfer;
        mem_en   = in_xfer;
        mem_we   = in_xfer && put_q;
        put_pull = in_xfer && put_q;
        cur_base = base_q;
        cur_code = code_q;
        cur_off  = (start_q + OFF_W'(idx_q)) & mask_q;
    end

    // Phase sequencing and capture of the command's ring context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= XS_IDLE;
            put_q      <= 1'b0;
            idx_q      <= '0;
            last_idx_q <= '0;
            start_q    <= '0;
            mask_q     <= '0;
            base_q     <= '0;
            code_q     <= '0;
        end else if (state_q == XS_IDLE) begin
            if (cmt_en) begin
                state_q    <= XS_XFER;
                put_q      <= cmd_put;
                idx_q      <= '0;
                last_idx_q <= cmd_len_m1;
                start_q    <= cmd_put ? sel_tail : sel_head;
                mask_q     <= sel_mask;
                base_q     <= sel_base;
                code_q     <= sel_code;
            end
        end else if (is_last) begin
            state_q <= XS_IDLE;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Response pipeline aligned with the one-cycle memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q  <= 1'b0;
            nil_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            rdv_q  <= (in_xfer && !put_q) || nil_start;
            nil_q  <= nil_start;
            done_q <= (in_xfer && is_last) || nil_start;
        end
    end

    assign rsp_valid = rdv_q;
    assign rsp_nil   = nil_q;
    assign done      = done_q;

    AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |-> (cur_off == (($past(cur_off) + 1'b1) & mask_q))); // R3

endmodule

// File: rtl/scr_ring_mgr.sv
// Top of the scratch ring manager.
// What: ties the context file, the command sequencer and the address builder
// together, gates configuration writes and forms the response word.
// Assumes: a single requester; a single-port memory with one-cycle read latency.
module scr_ring_mgr
    import scr_ring_pkg::*;
#(
    parameter int NUM_RINGS     = 16,
    parameter int MAX_LEN       = 16,
    parameter int ADDR_W        = 14,
    parameter int DATA_W        = 32,
    parameter int MIN_SIZE_LOG2 = 7,
    parameter int NUM_CODES     = 4,
    localparam int RING_W  = $clog2(NUM_RINGS),
    localparam int LEN_W   = $clog2(MAX_LEN),
    localparam int WADDR_W = ADDR_W - 2,
    localparam int BASE_W  = WADDR_W - MIN_SIZE_LOG2,
    localparam int CODE_W  = $clog2(NUM_CODES),
    localparam int OFF_W   = MIN_SIZE_LOG2 + NUM_CODES - 1,
    localparam int CNT_W   = OFF_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [RING_W-1:0]    cfg_ring,
    input  logic [1:0]           cfg_sel,
    input  logic [OFF_W-1:0]     cfg_wdata,
    input  logic                 cmd_valid,
    input  logic                 cmd_put,
    input  logic [RING_W-1:0]    cmd_ring,
    input  logic [LEN_W-1:0]     cmd_len_m1,
    output logic                 busy,
    output logic                 put_pull,
    input  logic [DATA_W-1:0]    put_data,
    output logic                 rsp_valid,
    output logic                 rsp_nil,
    output logic [DATA_W-1:0]    rsp_data,
    output logic                 done,
    output logic [NUM_RINGS-1:0] ring_full,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata
);

    logic              cfg_apply;
    logic              cmt_en;
    logic [LEN_W:0]    cmt_len;
    logic [BASE_W-1:0] sel_base;
    logic [CODE_W-1:0] sel_code;
    logic [OFF_W-1:0]  sel_head;
    logic [OFF_W-1:0]  sel_tail;
    logic [CNT_W-1:0]  sel_count;
    logic [OFF_W-1:0]  sel_mask;
    logic [BASE_W-1:0] cur_base;
    logic [CODE_W-1:0] cur_code;
    logic [OFF_W-1:0]  cur_off;

    // Configuration writes only land when no command is running or arriving.
    always_comb cfg_apply = cfg_we && !busy && !cmd_valid;

    ring_ctx_file #(
        .NUM_RINGS     (NUM_RINGS),
        .MAX_LEN       (MAX_LEN),
        .ADDR_W        (ADDR_W),
        .MIN_SIZE_LOG2 (MIN_SIZE_LOG2),
        .NUM_CODES     (NUM_CODES)
    ) i_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_apply),
        .cfg_ring  (cfg_ring),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cmt_en    (cmt_en),
        .cmt_put   (cmd_put),
        .cmt_ring  (cmd_ring),
        .cmt_len   (cmt_len),
        .rd_ring   (cmd_ring),
        .rd_base   (sel_base),
        .rd_code   (sel_code),
        .rd_head   (sel_head),
        .rd_tail   (sel_tail),
        .rd_count  (sel_count),
        .rd_mask   (sel_mask),
        .ring_full (ring_full)
    );

    ring_xfer_ctrl #(
        .MAX_LEN       (MAX_LEN),
        .ADDR_W        (ADDR_W),
        .MIN_SIZE_LOG2 (MIN_SIZE_LOG2),
        .NUM_CODES     (NUM_CODES)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_put    (cmd_put),
        .cmd_len_m1 (cmd_len_m1),
        .sel_base   (sel_base),
        .sel_code   (sel_code),
        .sel_head   (sel_head),
        .sel_tail   (sel_tail),
        .sel_count  (sel_count),
        .sel_mask   (sel_mask),
        .busy       (busy),
        .cmt_en     (cmt_en),
        .cmt_len    (cmt_len),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .put_pull   (put_pull),
        .cur_base   (cur_base),
        .cur_code   (cur_code),
        .cur_off    (cur_off),
        .rsp_valid  (rsp_valid),
        .rsp_nil    (rsp_nil),
        .done       (done)
    );

    ring_addr_gen #(
        .ADDR_W        (ADDR_W),
        .MIN_SIZE_LOG2 (MIN_SIZE_LOG2),
        .NUM_CODES     (NUM_CODES)
    ) i_addr (
        .base   (cur_base),
        .code   (cur_code),
        .offset (cur_off),
        .addr   (mem_addr)
    );

    // Write data passes straight from the requester; nil phases return zero.
    always_comb begin
        mem_wdata = put_data;
        rsp_data  = rsp_nil ? '0 : mem_rdata;
    end

    AST_NIL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nil |-> !$past(mem_en)); // R4
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (rsp_valid && !rsp_nil)); // R3
    AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rsp_nil) |-> $past(mem_en)); // R5

endmodule

// File: tb/test_scr_ring_mgr.sv
`timescale 1ns/1ps
module test_scr_ring_mgr;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ring = '0;
    logic [1:0]  cfg_sel = '0;
    logic [9:0]  cfg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_put = 1'b0;
    logic [3:0]  cmd_ring = '0;
    logic [3:0]  cmd_len_m1 = '0;
    logic        busy, put_pull, rsp_valid, rsp_nil, done, mem_en, mem_we;
    logic [31:0] put_data = '0;
    logic [31:0] rsp_data, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [15:0] ring_full;
    logic [13:0] mem_addr;

    logic [31:0] mem_m [4096];
    logic [31:0] ref_m [4096];
    logic [4:0]  r_base [16];
    logic [1:0]  r_code [16];
    logic [9:0]  r_head [16];
    logic [9:0]  r_tail [16];
    logic [10:0] r_cnt  [16];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(HALF) clk = ~clk;

    scr_ring_mgr i_scr_ring_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ring(cfg_ring),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid),
        .cmd_put(cmd_put), .cmd_ring(cmd_ring), .cmd_len_m1(cmd_len_m1),
        .busy(busy), .put_pull(put_pull), .put_data(put_data),
        .rsp_valid(rsp_valid), .rsp_nil(rsp_nil), .rsp_data(rsp_data),
        .done(done), .ring_full(ring_full), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one-cycle synchronous read.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_m[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem_m[mem_addr[13:2]];
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] size_mask(input logic [1:0] c);
        return 10'((128 << c) - 1);
    endfunction

    function automatic logic [13:0] exp_addr(input logic [4:0] b, input logic [1:0] c,
                                             input logic [9:0] o);
        case (c)
            2'd0:    return {b, o[6:0], 2'b00};
            2'd1:    return {b[4:1], o[7:0], 2'b00};
            2'd2:    return {b[4:2], o[8:0], 2'b00};
            default: return {b[4:3], o[9:0], 2'b00};
        endcase
    endfunction

    task automatic check_full();
        for (int r = 0; r < 16; r++)
            check("R8", $sformatf("ring_full[%0d]", r), 32'(ring_full[r]),
                  32'(r_cnt[r] >= 11'(32 << r_code[r])));
    endtask

    task automatic cfg_write(input int ring, input int sel, input logic [9:0] d);
        logic [9:0] m;
        @(negedge clk);
        cfg_we = 1'b1; cfg_ring = 4'(ring); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        m = size_mask(r_code[ring]);
        case (sel)
            0: begin
                r_base[ring] = d[4:0]; r_code[ring] = d[9:8];
                r_head[ring] = '0; r_tail[ring] = '0; r_cnt[ring] = '0;
            end
            1: begin
                r_head[ring] = d & m;
                r_cnt[ring]  = 11'((r_tail[ring] - r_head[ring]) & m);
            end
            2: begin
                r_tail[ring] = d & m;
                r_cnt[ring]  = 11'((r_tail[ring] - r_head[ring]) & m);
            end
            default: ;
        endcase
    endtask

    // poke 1: configuration write alongside the command; poke 2: command and
    // configuration write while busy (needs len >= 3).
    task automatic do_cmd(input bit put, input int ring, input int len, input int poke);
        logic [9:0]  m, start, off;
        logic [13:0] a, prev;
        logic [31:0] d;
        bit ok;
        m = size_mask(r_code[ring]);
        ok = put || (r_cnt[ring] >= 11'(len));
        start = put ? r_tail[ring] : r_head[ring];
        prev = '0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_put = put; cmd_ring = 4'(ring); cmd_len_m1 = 4'(len - 1);
        if (poke == 1) begin
            cfg_we = 1'b1; cfg_ring = 4'(ring); cfg_sel = 2'd1; cfg_wdata = 10'h3;
        end
        @(negedge clk);
        cmd_valid = 1'b0; cfg_we = 1'b0;
        if (!ok) begin
            check("R4", "nil rsp_valid", 32'(rsp_valid), 1);
            check("R4", "nil rsp_nil", 32'(rsp_nil), 1);
            check("R4", "nil rsp_data", rsp_data, 0);
            check("R4", "nil mem_en", 32'(mem_en), 0);
            check("R5", "nil done", 32'(done), 1);
        end else begin
            for (int i = 0; i < len; i++) begin
                off = (start + 10'(i)) & m;
                a = exp_addr(r_base[ring], r_code[ring], off);
                check("R7", "busy in phase", 32'(busy), 1);
                check(put ? "R6" : "R3", "mem_en", 32'(mem_en), 1);
                check(put ? "R6" : "R3", "mem_we", 32'(mem_we), 32'(put));
                check("R2", "mem_addr", 32'(mem_addr), 32'(a));
                if (put) begin
                    check("R6", "put_pull", 32'(put_pull), 1);
                    d = $urandom;
                    put_data = d;
                    ref_m[a[13:2]] = d;
                end else if (i > 0) begin
                    check("R3", "rsp_valid", 32'(rsp_valid), 1);
                    check("R3", "rsp_data", rsp_data, ref_m[prev[13:2]]);
                    check("R5", "early done", 32'(done), 0);
                end
                if (poke == 2 && i == 1) begin
                    cmd_valid = 1'b1; cmd_put = 1'b0; cmd_len_m1 = 4'd0;
                    cfg_we = 1'b1; cfg_ring = 4'(ring); cfg_sel = 2'd2; cfg_wdata = 10'h5;
                end
                if (poke == 2 && i == 2) begin
                    cmd_valid = 1'b0; cfg_we = 1'b0;
                end
                prev = a;
                @(negedge clk);
            end
            check(put ? "R12" : "R5", "done at end", 32'(done), 1);
            check("R7", "busy released", 32'(busy), 0);
            if (put) begin
                check("R6", "no rsp for put", 32'(rsp_valid), 0);
                r_tail[ring] = (r_tail[ring] + 10'(len)) & m;
                r_cnt[ring]  = r_cnt[ring] + 11'(len);
            end else begin
                check("R3", "last rsp_valid", 32'(rsp_valid), 1);
                check("R3", "last rsp_data", rsp_data, ref_m[prev[13:2]]);
                check("R4", "rsp_nil low", 32'(rsp_nil), 0);
                r_head[ring] = (r_head[ring] + 10'(len)) & m;
                r_cnt[ring]  = r_cnt[ring] - 11'(len);
            end
        end
        check_full();
    endtask

    initial begin
        #(HALF * 2.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) begin
            mem_m[i] = 32'(i) * 32'h9E37_79B9;
            ref_m[i] = 32'(i) * 32'h9E37_79B9;
        end
        for (int r = 0; r < 16; r++) begin
            r_base[r] = '0; r_code[r] = '0; r_head[r] = '0; r_tail[r] = '0; r_cnt[r] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", 32'(busy), 0);
        check("R1", "mem_en in reset", 32'(mem_en), 0);
        check("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        check("R1", "done in reset", 32'(done), 0);
        check("R1", "ring_full in reset", 32'(ring_full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", 32'(busy), 0);
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 0);

        // Layouts covering all four size codes (R9).
        cfg_write(0, 0, {2'd0, 3'd0, 5'h01});
        cfg_write(1, 0, {2'd1, 3'd0, 5'h04});
        cfg_write(2, 0, {2'd2, 3'd0, 5'h08});
        cfg_write(3, 0, {2'd3, 3'd0, 5'h10});

        do_cmd(1'b0, 0, 1, 0);              // R4: empty ring
        do_cmd(1'b1, 0, 16, 0);
        do_cmd(1'b1, 0, 15, 0);             // R8: 31, below threshold
        do_cmd(1'b1, 0, 1, 0);              // R8: 32, at threshold
        do_cmd(1'b0, 0, 16, 0);
        do_cmd(1'b0, 0, 16, 0);             // R3: exact count
        do_cmd(1'b0, 0, 1, 0);              // R4: one short

        // Wrap across the ring end (R3, R6, R10).
        cfg_write(0, 2, 10'd120);
        cfg_write(0, 1, 10'd120);
        do_cmd(1'b1, 0, 16, 0);
        do_cmd(1'b0, 0, 16, 0);

        // Count derived from pointer writes (R10).
        cfg_write(1, 2, 10'd100);
        check_full();
        cfg_write(1, 1, 10'd90);
        do_cmd(1'b0, 1, 11, 0);
        do_cmd(1'b0, 1, 10, 0);
        cfg_write(1, 2, 10'h3FF);           // R10: masked to 255
        do_cmd(1'b0, 1, 16, 0);

        // Dropped configuration writes (R11) and ignored commands (R7).
        do_cmd(1'b1, 2, 4, 1);
        do_cmd(1'b1, 2, 6, 2);
        do_cmd(1'b0, 2, 6, 2);
        cfg_write(2, 3, 10'h3FF);           // R10: no effect
        do_cmd(1'b0, 2, 4, 0);
        do_cmd(1'b0, 2, 1, 0);

        // Layout rewrite clears the ring (R9).
        do_cmd(1'b1, 3, 16, 0);
        cfg_write(3, 0, {2'd3, 3'd0, 5'h18});
        do_cmd(1'b0, 3, 1, 0);

        // PUT past capacity is never refused (R6).
        for (int k = 0; k < 9; k++) do_cmd(1'b1, 0, 16, 0);

        // Random layouts and traffic.
        for (int r = 0; r < 16; r++) cfg_write(r, 0, 10'($urandom));
        for (int n = 0; n < 400; n++) begin
            int r, len;
            bit put;
            r = $urandom % 16;
            len = 1 + ($urandom % 16);
            put = $urandom % 2;
            if (put && (int'(r_cnt[r]) + len > (128 << r_code[r]))) put = 1'b0;
            do_cmd(put, r, len, (len >= 3 && ($urandom % 8) == 0) ? 2 : 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule